// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block is a register-mapped pulse-width modulator. A 16-bit counter advances on a prescaled tick and spans one output period. The output starts each period high and drops when the counter reaches the duty value that is currently active. Duty values are not written straight to the comparator. They queue in a four-entry FIFO, and each queued value can be held for 1, 2, 4 or 8 periods before the next one is taken. When the queue runs dry, the last value stays in use.

Software programs a control word that holds the enable, the repeat code, the prescaler, the tick source and the output mode. It writes the period register and pushes duty samples through the sample register. It polls a status word that gives the queue fill level and sticky event flags. Writing 1 to a self-clearing soft-reset bit returns every register to its reset value and flushes the queue. Three tick-source inputs let the integrating chip offer different clock-enable rates. Source code 0 parks the counter.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset the status word reads 0x08, the control word reads 0, the period register reads 0xFFFE, the sample register reads 0 and `pwm_out` is low.
- R2: With a period register value P, one output period lasts P+2 counter ticks. A value of 0xFFFF gives exactly the same period as 0xFFFE, which is 65536 ticks.
- R3: Control bits 15:4 hold a prescaler value D. The counter advances once every D+1 pulses of the selected tick source.
- R4: A write to offset 0x0C pushes wdata[15:0] into a four-entry FIFO. Status bits 2:0 give the number of queued entries (0 to 4). Entries are consumed in write order, one when the enable rises and one at each period boundary where the repeat count is used up.
- R5: A sample write while the FIFO holds 4 entries is dropped, and it sets the write-error flag in status bit 6.
- R6: Control bits 2:1 set how many periods each sample lasts: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R7: Control bits 19:18 select the output mode. Code 0 is normal. Code 1 inverts the output. Codes 2 and 3 hold `pwm_out` low.
- R8: In normal mode the output is high from the start of a period until the counter equals the active sample, so a sample S gives S high ticks per period (when S is at most P+2). A sample of 0 keeps the output low.
- R9: If the FIFO is empty at a period boundary, the active sample is kept. Status bit 3 (empty) is set whenever the FIFO holds no entries.
- R10: Control bits 17:16 select tick source 1 to 3 (`src_tick[code-1]`), and code 0 holds the counter still. When control bit 0 (enable) is low, the counter stays at 0 and the normal-mode output is low.
- R11: Writing 1 to control bit 3 starts a soft reset. The bit reads 1 for SRST_CYCLES cycles and then clears itself. Afterwards every register has its reset value and the FIFO is empty.
- R12: Status bit 4 is set at each counter wrap, and status bit 5 is set when the counter steps onto a nonzero active sample. Bits 4, 5 and 6 stay set until they are cleared by writing 1 to them at offset 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register (0x00 control, 0x04 status, 0x0C sample, 0x10 period) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_tick | input | 3 | Clock-enable pulses of tick sources 1 to 3 |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench uses the default parameters: a FIFO depth of four, a soft reset that lasts four cycles, and all three tick sources held high. With these values, the output is measured high-tick by high-tick and every period window is aligned to the cycle. Short periods of 6 and 2 make it cheap to step through queue ordering, repeat codes, underrun hold, inversion and prescaling. A single full-length run with period 0xFFFF and sample 0xFFFF pins the saturated period at 65536 ticks: it checks that the wrap flag stays clear one tick before the end of the period and is set right after it.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

    localparam int BUS_W = 32;
    localparam int CNT_W = 16;
    localparam int PRE_W = 12;
    localparam int REP_W = 2;
    localparam int SRC_W = 2;

    // register offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_STAT   = 8'h04;
    localparam logic [7:0] OFS_SAMPLE = 8'h0C;
    localparam logic [7:0] OFS_PERIOD = 8'h10;

    // control word bit positions
    localparam int CB_EN      = 0;
    localparam int CB_REP_LO  = 1;
    localparam int CB_SRST    = 3;
    localparam int CB_PRE_LO  = 4;
    localparam int CB_SRC_LO  = 16;
    localparam int CB_MODE_LO = 18;

    // status word bit positions
    localparam int SB_LVL_LO = 0;
    localparam int SB_EMPTY  = 3;
    localparam int SB_ROV    = 4;
    localparam int SB_CMP    = 5;
    localparam int SB_WERR   = 6;

    localparam logic [CNT_W-1:0] PERIOD_RESET = 16'hFFFE;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_INVERT  = 2'd1,
        MODE_OFF     = 2'd2,
        MODE_OFF_ALT = 2'd3
    } out_mode_e;

    typedef struct packed {
        out_mode_e        mode;
        logic [SRC_W-1:0] src;
        logic [PRE_W-1:0] pre;
        logic [REP_W-1:0] rep;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        logic rov;
        logic cmp;
    } core_evt_t;

    // the all-ones period code behaves like the code just below it
    function automatic logic [CNT_W-1:0] sat_period(input logic [CNT_W-1:0] raw);
        return (raw == '1) ? raw - 1'b1 : raw;
    endfunction

    // last index of the repeat counter for a repeat code: 1, 2, 4 or 8 periods
    function automatic logic [3:0] rep_last(input logic [REP_W-1:0] code);
        return (4'd1 << code) - 4'd1;
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctrl(input ctrl_t c, input logic busy);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CB_EN]                   = c.en;
        w[CB_REP_LO +: REP_W]      = c.rep;
        w[CB_SRST]                 = busy;
        w[CB_PRE_LO +: PRE_W]      = c.pre;
        w[CB_SRC_LO +: SRC_W]      = c.src;
        w[CB_MODE_LO +: 2]         = c.mode;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [BUS_W-1:0] w);
        ctrl_t c;
        c.en   = w[CB_EN];
        c.rep  = w[CB_REP_LO +: REP_W];
        c.pre  = w[CB_PRE_LO +: PRE_W];
        c.src  = w[CB_SRC_LO +: SRC_W];
        c.mode = out_mode_e'(w[CB_MODE_LO +: 2]);
        return c;
    endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             src_tick,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic             at_div;

    assign at_div = (pcnt >= div);
    assign tick   = run && src_tick && at_div;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt <= '0;
        end else if (run && src_tick) begin
            pcnt <= at_div ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core
    import pwm_fifo_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             start,
    input  logic             tick,
    input  logic [W-1:0]     period_raw,
    input  logic [REP_W-1:0] rep_code,
    input  logic             fifo_empty,
    input  logic [W-1:0]     fifo_head,
    output logic             pop,
    output logic             wrap,
    output logic [W-1:0]     active,
    output logic [W-1:0]     cnt,
    output core_evt_t        evt,
    output logic             raw_out
);
    logic [W-1:0] term;
    logic [W-1:0] cnt_nxt;
    logic [3:0]   rep_cnt;
    logic         rep_done;
    logic         load;

    assign term     = sat_period(period_raw) + 1'b1;
    assign wrap     = tick && (cnt >= term);
    assign cnt_nxt  = wrap ? '0 : cnt + 1'b1;
    assign rep_done = (rep_cnt >= rep_last(rep_code));
    assign load     = start || (wrap && rep_done);
    assign pop      = load && !fifo_empty;

    assign evt.rov  = wrap;
    assign evt.cmp  = tick && (active != '0) && (cnt_nxt == active);
    assign raw_out  = en && (cnt < active);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt     <= '0;
            rep_cnt <= '0;
            active  <= '0;
        end else begin
            if (!en || start) begin
                cnt     <= '0;
                rep_cnt <= '0;
            end else if (tick) begin
                cnt <= cnt_nxt;
                if (wrap) begin
                    rep_cnt <= rep_done ? 4'd0 : rep_cnt + 4'd1;
                end
            end
            if (pop) begin
                active <= fifo_head;
            end
        end
    end
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SRST_CYCLES = 4,
    parameter int ADDR_W      = 8,
    parameter int NUM_SRC     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic              pwm_out
);
    localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
    localparam int SRST_W = $clog2(SRST_CYCLES + 1);

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  period_q;
    logic              rov_q, cmp_q, werr_q;
    logic              busy;
    logic [SRST_W-1:0] srst_cnt;
    logic              en_d;

    logic wr_ctrl, wr_stat, wr_sample, wr_period;
    logic core_en, start, run, sel_tick, tick;

    logic [CNT_W-1:0] fifo_head;
    logic [LVL_W-1:0] fifo_level;
    logic             fifo_full, fifo_empty;
    logic             pop, wrap, raw_out;
    logic [CNT_W-1:0] active, cnt;
    core_evt_t        evt;

    // ---------------- register decode ----------------
    assign wr_ctrl   = wr_en && !busy && (addr == ADDR_W'(OFS_CTRL));
    assign wr_stat   = wr_en && !busy && (addr == ADDR_W'(OFS_STAT));
    assign wr_sample = wr_en && !busy && (addr == ADDR_W'(OFS_SAMPLE));
    assign wr_period = wr_en && !busy && (addr == ADDR_W'(OFS_PERIOD));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= PERIOD_RESET;
            busy     <= 1'b0;
            srst_cnt <= '0;
        end else if (busy) begin
            ctrl_q   <= '0;
            period_q <= PERIOD_RESET;
            if (srst_cnt == '0) begin
                busy <= 1'b0;
            end else begin
                srst_cnt <= srst_cnt - 1'b1;
            end
        end else begin
            if (wr_ctrl) begin
                if (wdata[CB_SRST]) begin
                    busy     <= 1'b1;
                    srst_cnt <= SRST_W'(SRST_CYCLES - 1);
                end else begin
                    ctrl_q <= unpack_ctrl(wdata);
                end
            end
            if (wr_period) begin
                period_q <= wdata[CNT_W-1:0];
            end
        end
    end

    // sticky flags, set has priority over clear
    always_ff @(posedge clk) begin
        if (rst || busy) begin
            rov_q  <= 1'b0;
            cmp_q  <= 1'b0;
            werr_q <= 1'b0;
            en_d   <= 1'b0;
        end else begin
            en_d   <= ctrl_q.en;
            rov_q  <= evt.rov | (rov_q & ~(wr_stat & wdata[SB_ROV]));
            cmp_q  <= evt.cmp | (cmp_q & ~(wr_stat & wdata[SB_CMP]));
            werr_q <= (wr_sample & fifo_full) | (werr_q & ~(wr_stat & wdata[SB_WERR]));
        end
    end

    // ---------------- tick source selection ----------------
    always_comb begin
        sel_tick = 1'b0;
        for (int s = 1; s <= NUM_SRC; s++) begin
            if (int'(ctrl_q.src) == s) begin
                sel_tick = src_tick[s-1];
            end
        end
    end

    assign core_en = ctrl_q.en && !busy;
    assign start   = core_en && !en_d;
    assign run     = core_en && en_d && (ctrl_q.src != '0);

    pwm_prescale #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (!core_en),
        .run      (run),
        .src_tick (sel_tick),
        .div      (ctrl_q.pre),
        .tick     (tick)
    );

    pwm_sample_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (CNT_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (busy),
        .push  (wr_sample),
        .wdata (wdata[CNT_W-1:0]),
        .pop   (pop),
        .head  (fifo_head),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    pwm_period_core #(
        .W (CNT_W)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .clr        (busy),
        .en         (core_en),
        .start      (start),
        .tick       (tick),
        .period_raw (period_q),
        .rep_code   (ctrl_q.rep),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .pop        (pop),
        .wrap       (wrap),
        .active     (active),
        .cnt        (cnt),
        .evt        (evt),
        .raw_out    (raw_out)
    );

    // ---------------- output stage ----------------
    always_comb begin
        unique case (ctrl_q.mode)
            MODE_NORMAL: pwm_out = raw_out;
            MODE_INVERT: pwm_out = !raw_out;
            default:     pwm_out = 1'b0;
        endcase
    end

    // ---------------- read mux ----------------
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL)) begin
            rdata = pack_ctrl(ctrl_q, busy);
        end else if (addr == ADDR_W'(OFS_STAT)) begin
            rdata[SB_LVL_LO +: LVL_W] = fifo_level;
            rdata[SB_EMPTY]           = fifo_empty;
            rdata[SB_ROV]             = rov_q;
            rdata[SB_CMP]             = cmp_q;
            rdata[SB_WERR]            = werr_q;
        end else if (addr == ADDR_W'(OFS_SAMPLE)) begin
            rdata[CNT_W-1:0] = active;
        end else if (addr == ADDR_W'(OFS_PERIOD)) begin
            rdata[CNT_W-1:0] = period_q;
        end
    end
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk
    import pwm_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int LVL_W      = 3,
    parameter int ADDR_W     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              busy,
    input logic [LVL_W-1:0]  level,
    input logic              full,
    input logic              empty,
    input logic              pop,
    input logic              werr,
    input logic              rov,
    input logic              rov_evt,
    input logic              wrap,
    input logic              en,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  active,
    input logic              pwm_out
);
    logic sample_wr;
    assign sample_wr = wr_en && !busy && (addr == ADDR_W'(OFS_SAMPLE));

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= FIFO_DEPTH); // R4

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (sample_wr && full && !pop) |=> (werr && level == $past(level))); // R5

    AST_OFF_MODE_LOW: assert property (@(posedge clk) disable iff (rst)
        mode[1] |-> !pwm_out); // R7

    AST_ZERO_SAMPLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && active == '0) |-> !pwm_out); // R8

    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wrap && empty) |=> $stable(active)); // R9

    AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0)); // R10

    AST_SRST_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        busy |=> (level == '0)); // R11

    AST_ROV_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rov_evt && !busy) |=> rov); // R12
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .LVL_W      (LVL_W),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .busy    (busy),
    .level   (fifo_level),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .pop     (pop),
    .werr    (werr_q),
    .rov     (rov_q),
    .rov_evt (evt.rov),
    .wrap    (wrap),
    .en      (core_en),
    .mode    (ctrl_q.mode),
    .cnt     (cnt),
    .active  (active),
    .pwm_out (pwm_out)
);

// File: tb/tb_pwm_fifo_gen.sv
module tb_pwm_fifo_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  src_tick = 3'b111;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_SMP = 8'h0C, A_PER = 8'h10;
    localparam logic [31:0] C_EN = 32'h1, C_SRC1 = 32'h1_0000, C_SRST = 32'h8;
    localparam logic [31:0] C_INV = 32'h4_0000, C_OFF = 32'h8_0000;

    pwm_fifo_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .src_tick(src_tick), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic soft_reset();
        bus_wr(A_CTRL, C_SRST);
        repeat (8) @(negedge clk);
    endtask

    // enable write then step to the first negedge of period 0
    task automatic start_run(input logic [31:0] ctrl_val);
        bus_wr(A_CTRL, ctrl_val);
        @(negedge clk);
    endtask

    task automatic measure(input int n, output int ones);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) ones++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(A_STAT, d);   chk("R1 status after reset", d, 32'h08);
        bus_rd(A_CTRL, d);   chk("R1 control after reset", d, 32'h0);
        bus_rd(A_PER, d);    chk("R1 period after reset", d, 32'hFFFE);
        bus_rd(A_SMP, d);    chk("R1 sample after reset", d, 32'h0);
        chk("R1 output after reset", {31'b0, pwm_out}, 32'h0);
    endtask

    task automatic t_fifo_and_srst();
        logic [31:0] d;
        bus_wr(A_PER, 32'd6);
        for (int i = 0; i < 4; i++) bus_wr(A_SMP, 32'd10 + i);
        bus_rd(A_STAT, d);   chk("R4 level four", d, 32'h04);
        bus_wr(A_SMP, 32'd99);
        bus_rd(A_STAT, d);   chk("R5 write to full fifo", d, 32'h44);
        bus_wr(A_STAT, 32'h40);
        bus_rd(A_STAT, d);   chk("R12 werr cleared by write-one", d, 32'h04);
        bus_wr(A_CTRL, C_SRST);
        bus_rd(A_CTRL, d);   chk("R11 reset bit reads busy", d, 32'h08);
        repeat (6) @(negedge clk);
        bus_rd(A_CTRL, d);   chk("R11 reset bit self-clears", d, 32'h0);
        bus_rd(A_STAT, d);   chk("R11 fifo flushed", d, 32'h08);
        bus_rd(A_PER, d);    chk("R11 period restored", d, 32'hFFFE);
    endtask

    task automatic t_sequence();
        logic [31:0] d;
        int ones;
        soft_reset();
        bus_wr(A_PER, 32'd6);
        bus_wr(A_SMP, 32'd2);
        bus_wr(A_SMP, 32'd5);
        bus_wr(A_SMP, 32'd0);
        start_run(C_EN | C_SRC1);
        measure(8, ones); chk("R8 R2 first sample 2 of 8", ones, 2);
        measure(8, ones); chk("R4 second sample 5 of 8", ones, 5);
        measure(8, ones); chk("R8 zero sample all low", ones, 0);
        measure(8, ones); chk("R9 held sample after underrun", ones, 0);
        bus_rd(A_STAT, d); chk("R12 R9 flags after run", d, 32'h38);
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_STAT, 32'h30);
        bus_rd(A_STAT, d); chk("R12 rov and cmp cleared", d, 32'h08);
        measure(10, ones); chk("R10 disabled output low", ones, 0);
    endtask

    task automatic t_repeat();
        int ones;
        soft_reset();
        bus_wr(A_PER, 32'd6);
        bus_wr(A_SMP, 32'd3);
        bus_wr(A_SMP, 32'd6);
        start_run(C_EN | C_SRC1 | 32'h2);
        measure(8, ones); chk("R6 2x first period", ones, 3);
        measure(8, ones); chk("R6 2x repeat period", ones, 3);
        measure(8, ones); chk("R6 2x next sample", ones, 6);
        measure(8, ones); chk("R6 2x next sample repeat", ones, 6);
        soft_reset();
        bus_wr(A_PER, 32'd6);
        bus_wr(A_SMP, 32'd1);
        bus_wr(A_SMP, 32'd4);
        start_run(C_EN | C_SRC1 | 32'h4);
        for (int p = 0; p < 4; p++) begin
            measure(8, ones); chk("R6 4x held sample", ones, 1);
        end
        measure(8, ones); chk("R6 4x next sample", ones, 4);
    endtask

    task automatic t_modes();
        int ones;
        soft_reset();
        bus_wr(A_PER, 32'd6);
        bus_wr(A_SMP, 32'd3);
        start_run(C_EN | C_SRC1 | C_INV);
        measure(8, ones); chk("R7 inverted", ones, 5);
        bus_wr(A_CTRL, C_EN | C_SRC1 | C_OFF);
        measure(20, ones); chk("R7 forced off", ones, 0);
        bus_wr(A_CTRL, C_EN | C_SRC1);
        measure(8, ones); chk("R7 back to normal", ones, 3);
    endtask

    task automatic t_prescale();
        int ones;
        soft_reset();
        bus_wr(A_PER, 32'd2);
        bus_wr(A_SMP, 32'd1);
        start_run(C_EN | C_SRC1 | 32'h20);
        measure(12, ones); chk("R3 divide by 3 first period", ones, 3);
        measure(12, ones); chk("R3 divide by 3 second period", ones, 3);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        int ones;
        soft_reset();
        bus_wr(A_PER, 32'd6);
        bus_wr(A_SMP, 32'd3);
        bus_wr(A_CTRL, C_SRC1);
        measure(20, ones); chk("R10 enable low output", ones, 0);
        bus_rd(A_STAT, d); chk("R10 enable low no pop", d, 32'h01);
        start_run(C_EN);
        measure(40, ones); chk("R10 source 0 counter held", ones, 40);
        bus_rd(A_STAT, d); chk("R10 source 0 no wrap", d, 32'h08);
    endtask

    task automatic t_big_period();
        logic [31:0] d;
        int ones, last;
        soft_reset();
        bus_wr(A_PER, 32'hFFFF);
        bus_wr(A_SMP, 32'hFFFF);
        start_run(C_EN | C_SRC1);
        measure(65535, ones);
        bus_rd(A_STAT, d); chk("R2 no wrap before 65536 ticks", d & 32'h10, 32'h0);
        measure(1, last);
        chk("R2 saturated period high ticks", ones + last, 65535);
        bus_rd(A_STAT, d); chk("R2 wrap at 65536 ticks", d & 32'h10, 32'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fifo_and_srst();
        t_sequence();
        t_repeat();
        t_modes();
        t_prescale();
        t_stop();
        t_big_period();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule